// File: doc/BRIEF.md
# Comma-Density Link Lock Monitor

This block watches a recovered 8b/10b bit stream that arrives as 32-bit words, one per clock when a valid strobe is high. It counts how often the K28.5 comma symbol appears at any bit alignment, including symbols that straddle two consecutive words. It makes that count over a measurement window whose length is set by a 4-bit exponent.

When a window closes, the block compares the count with a programmable 12-bit minimum. It reports the link as locked when the count meets the minimum and as unlocked when the count falls short. The same window result can also set a sticky interrupt flag when the count comes up short. Lock reporting and interrupt generation have separate enables. A master enable gates all checking.

The block is meant to sit behind a deserializer in a receive lane. It lets firmware or a link state machine tell a healthy, correctly framed lane from a lane that has lost bit alignment or is carrying noise.

Top module: `comma_lock_chk`

## Requirements
- R1: After a synchronous reset, `lock`, `irq` and `win_count` are all zero.
- R2: Bit 0 of each word is the first bit received. The previous valid word's bits 31:23 are kept as history, and together with the new word they form a 41-bit vector `{din, history}`. A hit is counted for every start position j in 0..31 where bits j+9..j equal 10'b0101111100 or 10'b1010000011. These are the comma symbol and its complement, written with the first-received bit in bit 0. Symbols that straddle a word boundary are therefore counted once. The history changes only on valid words and is zero after reset or while disabled.
- R3: A window is exactly 2^P valid words, where P = `cfg_period` (0..15). Words with `din_vld` low neither advance the window nor contribute hits.
- R4: On the clock edge that accepts the last word of a window with `cfg_lock_en` high, `lock` becomes 1 if the window's count is at least `cfg_min`, and 0 otherwise. The result is visible from the following cycle.
- R5: The per-window hit count saturates at 4095 instead of wrapping.
- R6: When `cfg_min` is 0, every completed window reports lock (given `cfg_lock_en` high).
- R7: `irq` sets when a window ends with its count below `cfg_min` while `cfg_irq_en` is high. It stays set until `irq_clr` is pulsed. A set in the same cycle as a clear wins.
- R8: While `cfg_en` is low, the window position, the hit count and the history are held cleared, and `lock`, `irq` and `win_count` keep their values. After re-enabling, a fresh window starts, and hits seen before disabling do not count.
- R9: `win_count` takes the count of every completed window, whatever the state of `cfg_lock_en` and `cfg_irq_en`.
- R10: While `cfg_lock_en` is low, completed windows leave `lock` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Received data word, bit 0 first in time |
| din_vld | input | 1 | Word valid strobe |
| cfg_en | input | 1 | Master enable for comma checking |
| cfg_lock_en | input | 1 | Allow window results to update `lock` |
| cfg_irq_en | input | 1 | Allow short windows to set `irq` |
| cfg_period | input | 4 | Window exponent P, window = 2^P words |
| cfg_min | input | 12 | Minimum comma count for lock |
| irq_clr | input | 1 | Pulse to clear the sticky interrupt |
| lock | output | 1 | Registered lock status |
| irq | output | 1 | Sticky loss-of-lock interrupt |
| win_count | output | 12 | Comma count of the last completed window |

## Verification
Directed words place single commas at offsets inside a word and at offsets 23, 27 and 31, where the symbol crosses into the next word. These words separate correct history handling from word-local scanning. Windows built with exactly N commas are checked against minimums of N and N+1 at several window lengths, which exposes off-by-one errors in both the comparison and the window length. A continuous comma stream over a 2048-word window drives the count into saturation, and words sent with the strobe low or the enable low show that they have no effect. Random mixes of empty words, single and double commas and random data, with random gaps, are compared window by window against a bench model of the counting rules.

// File: rtl/comma_lock_pkg.sv
package comma_lock_pkg;
  localparam int SYM_W = 10;
  // comma symbol with the first received bit in bit 0
  localparam logic [SYM_W-1:0] COMMA_POS = 10'b0101111100;
  localparam logic [SYM_W-1:0] COMMA_NEG = ~COMMA_POS;
endpackage

// File: rtl/comma_scan.sv
module comma_scan
  import comma_lock_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HIT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              vld,
  input  logic [WORD_W-1:0] din,
  output logic [HIT_W-1:0]  hits
);
  localparam int HIST_W = SYM_W - 1;
  localparam int EXT_W  = WORD_W + HIST_W;

  logic [HIST_W-1:0] hist;
  logic [EXT_W-1:0]  ext;
  logic [WORD_W-1:0] match;

  assign ext = {din, hist};

  // one comparator pair per start position; positions 0..8 straddle
  for (genvar g = 0; g < WORD_W; g++) begin : g_pos
    assign match[g] = (ext[g +: SYM_W] == COMMA_POS) ||
                      (ext[g +: SYM_W] == COMMA_NEG);
  end

  always_comb begin
    hits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (match[i]) hits = hits + HIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  hist <= '0;
    else if (vld)    hist <= din[WORD_W-1 -: HIST_W];
  end

  assert_hist_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> hist == '0);
  assert_hit_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (|match) |-> hits != '0);
endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int PER_W  = 4,
  parameter int WCNT_W = (1 << PER_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic [PER_W-1:0] period,
  output logic             last
);
  logic [WCNT_W-1:0] cnt;
  logic [WCNT_W:0]   span;
  logic [WCNT_W-1:0] limit;

  assign span  = {{WCNT_W{1'b0}}, 1'b1} << period;
  assign limit = span[WCNT_W-1:0] - WCNT_W'(1);
  assign last  = vld && !clr && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (vld)    cnt <= last ? '0 : cnt + WCNT_W'(1);
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    last |=> cnt == '0);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!vld && !clr) |=> $stable(cnt));
endmodule

// File: rtl/hit_accum.sv
module hit_accum #(
  parameter int CNT_W = 12,
  parameter int HIT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic             last,
  input  logic [HIT_W-1:0] hits,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] acc;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, acc} + (CNT_W + 1)'(hits);
  assign total = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (vld)   acc <= last ? '0 : total;
  end

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (vld && !clr && !last && acc == '1) |=> acc == '1);
  assert_acc_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);
endmodule

// File: rtl/comma_lock_chk.sv
module comma_lock_chk #(
  parameter int WORD_W = 32,
  parameter int PER_W  = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              din_vld,
  input  logic              cfg_en,
  input  logic              cfg_lock_en,
  input  logic              cfg_irq_en,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_min,
  input  logic              irq_clr,
  output logic              lock,
  output logic              irq,
  output logic [CNT_W-1:0]  win_count
);
  localparam int HIT_W = $clog2(WORD_W + 1);

  logic             clr;
  logic             last;
  logic             win_end;
  logic             short_win;
  logic [HIT_W-1:0] hits;
  logic [CNT_W-1:0] total;

  assign clr       = !cfg_en;
  assign win_end   = cfg_en && din_vld && last;
  assign short_win = total < cfg_min;

  comma_scan #(.WORD_W(WORD_W), .HIT_W(HIT_W)) u_scan (
    .clk(clk), .rst(rst), .clr(clr), .vld(din_vld), .din(din), .hits(hits)
  );

  win_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .vld(din_vld), .period(cfg_period),
    .last(last)
  );

  hit_accum #(.CNT_W(CNT_W), .HIT_W(HIT_W)) u_accum (
    .clk(clk), .rst(rst), .clr(clr), .vld(din_vld), .last(last),
    .hits(hits), .total(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock      <= 1'b0;
      irq       <= 1'b0;
      win_count <= '0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (win_end) begin
        win_count <= total;
        if (cfg_lock_en)              lock <= !short_win;
        if (cfg_irq_en && short_win)  irq  <= 1'b1;
      end
    end
  end

  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!win_end || !cfg_lock_en) |=> $stable(lock));
  assert_min_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (win_end && cfg_lock_en && cfg_min == '0) |=> lock);
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(win_count));
endmodule

// File: tb/test_comma_lock_chk.sv
module test_comma_lock_chk;
  localparam logic [9:0] PAT  = 10'b0101111100;
  localparam logic [9:0] NPAT = 10'b1010000011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic        din_vld = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_lock_en = 1'b0;
  logic        cfg_irq_en = 1'b0;
  logic [3:0]  cfg_period = '0;
  logic [11:0] cfg_min = '0;
  logic        irq_clr = 1'b0;
  logic        lock;
  logic        irq;
  logic [11:0] win_count;

  int checks = 0;
  int failures = 0;
  int m_acc = 0, m_wc = 0, m_last = 0, m_lock = 0, m_irq = 0;
  logic [8:0] m_prev = '0;
  bit ended = 0;

  always #10 clk = ~clk;

  comma_lock_chk i_comma_lock_chk (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .cfg_en(cfg_en),
    .cfg_lock_en(cfg_lock_en), .cfg_irq_en(cfg_irq_en),
    .cfg_period(cfg_period), .cfg_min(cfg_min), .irq_clr(irq_clr),
    .lock(lock), .irq(irq), .win_count(win_count)
  );

  function automatic int ref_hits(input logic [8:0] p, input logic [31:0] w);
    logic [40:0] e;
    int n;
    e = {w, p};
    n = 0;
    for (int j = 0; j < 32; j++)
      if (e[j +: 10] == PAT || e[j +: 10] == NPAT) n++;
    return n;
  endfunction

  function automatic logic [31:0] stream_word(input int idx);
    logic [31:0] w;
    for (int b = 0; b < 32; b++) w[b] = PAT[(idx * 32 + b) % 10];
    return w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic v);
    din = w;
    din_vld = v;
    @(negedge clk);
    din_vld = 1'b0;
    ended = 0;
    if (cfg_en && v) begin
      m_acc = m_acc + ref_hits(m_prev, w);
      if (m_acc > 4095) m_acc = 4095;
      m_prev = w[31:23];
      m_wc++;
      if (m_wc == (1 << cfg_period)) begin
        ended = 1;
        m_last = m_acc;
        if (cfg_lock_en) m_lock = (m_acc >= cfg_min) ? 1 : 0;
        if (cfg_irq_en && m_acc < cfg_min) m_irq = 1;
        m_acc = 0;
        m_wc = 0;
      end
    end
  endtask

  task automatic send_pair(input int k);
    logic [63:0] s;
    s = 64'(PAT) << k;
    send(s[31:0], 1'b1);
    send(s[63:32], 1'b1);
  endtask

  task automatic restart(input int p, input int mn, input bit le, input bit ie);
    cfg_en = 1'b0;
    @(negedge clk);
    cfg_period = 4'(p);
    cfg_min = 12'(mn);
    cfg_lock_en = le;
    cfg_irq_en = ie;
    cfg_en = 1'b1;
    m_acc = 0;
    m_wc = 0;
    m_prev = '0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    m_irq = 0;
  endtask

  task automatic check_all(input string tag);
    check({tag, " lock"}, int'(lock), m_lock);
    check({tag, " irq"}, int'(irq), m_irq);
    check({tag, " count"}, int'(win_count), m_last);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 lock", int'(lock), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 count", int'(win_count), 0);

    // R4/R9: P=2, four commas at in-word offsets, minimum 3
    restart(2, 3, 1, 0);
    send(32'(PAT) << 0, 1'b1);
    send(32'(PAT) << 5, 1'b1);
    send(32'(PAT) << 22, 1'b1);
    send(32'(PAT) << 13, 1'b1);
    check("R4 lock above min", int'(lock), 1);
    check("R9 count", int'(win_count), 4);

    // R2: straddling commas, P=1
    restart(1, 2, 1, 0);
    send_pair(27);
    check("R2 straddle 27 count", int'(win_count), 1);
    check("R4 loss below min", int'(lock), 0);
    restart(1, 1, 1, 0);
    send_pair(31);
    check("R2 straddle 31 count", int'(win_count), 1);
    check("R4 lock at min", int'(lock), 1);
    send_pair(23);
    check("R2 straddle 23 count", int'(win_count), 1);

    // R4/R7: P=3, five commas, minimum 5 then 6
    restart(3, 5, 1, 1);
    for (int i = 0; i < 8; i++) send(i < 5 ? 32'(PAT) << (i * 4) : 32'h0, 1'b1);
    check_all("R4 exact min P3");
    restart(3, 6, 1, 1);
    for (int i = 0; i < 8; i++) send(i < 5 ? 32'(PAT) << (i * 4) : 32'h0, 1'b1);
    check("R4 one short P3", int'(lock), 0);
    check("R7 irq set", int'(irq), 1);
    for (int i = 0; i < 8; i++) send(32'(PAT) << i, 1'b1);
    check("R7 irq sticky", int'(irq), 1);
    check("R4 relock", int'(lock), 1);
    pulse_clr();
    check("R7 irq cleared", int'(irq), 0);

    // R3: invalid words ignored
    restart(1, 1, 1, 0);
    send(32'h0, 1'b1);
    send(32'(PAT) << 3, 1'b0);
    check("R3 no early end", int'(lock), 1);
    send(32'h0, 1'b1);
    check("R3 invalid ignored count", int'(win_count), 0);
    check("R3 invalid ignored lock", int'(lock), 0);

    // R6: minimum zero
    restart(0, 0, 1, 0);
    send(32'h0, 1'b1);
    check("R6 zero min lock", int'(lock), 1);

    // R10: lock enable low
    restart(0, 5, 0, 0);
    send(32'h0, 1'b1);
    check("R10 lock held", int'(lock), 1);
    check("R10 count still updates", int'(win_count), 0);

    // R8: disable discards partial window and ignores traffic
    restart(1, 1, 1, 0);
    send(32'(PAT), 1'b1);
    cfg_en = 1'b0;
    m_acc = 0; m_wc = 0; m_prev = '0;
    for (int i = 0; i < 3; i++) send(32'(PAT) << 2, 1'b1);
    check_all("R8 disabled hold");
    restart(1, 1, 1, 0);
    send(32'h0, 1'b1);
    send(32'h0, 1'b1);
    check("R8 partial discarded count", int'(win_count), 0);
    check("R8 partial discarded lock", int'(lock), 0);

    // R5: saturation with a continuous comma stream, P=11
    restart(11, 4095, 1, 0);
    for (int i = 0; i < 2048; i++) send(stream_word(i), 1'b1);
    check("R5 saturated count", int'(win_count), 4095);
    check("R5 lock at max", int'(lock), 1);

    // random mix checked against the model
    for (int r = 0; r < 6; r++) begin
      restart($urandom_range(0, 4), $urandom_range(0, 6), 1, 1);
      for (int n = 0; n < 60; n++) begin
        int kind;
        int a;
        logic [31:0] w;
        kind = $urandom_range(0, 3);
        a = $urandom_range(0, 6);
        case (kind)
          0: w = 32'h0;
          1: w = 32'(PAT) << $urandom_range(0, 22);
          2: w = $urandom();
          default: w = (32'(PAT) << a) | (32'(PAT) << (a + 16));
        endcase
        send(w, $urandom_range(0, 4) != 0);
        if (ended) check_all("R2 R4 R7 random");
      end
      pulse_clr();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule